// File: doc/BRIEF.md
# Configurable-Length Synchronous Serial Receiver

This block is the receive half of a select-framed synchronous serial link (SPI-like, clock idle low, data sampled on the rising serial clock edge). While the active-low select input is low, it shifts in serial data and builds one frame of one, two or four bytes. Each byte arrives either least-significant bit first or most-significant bit first. At the end of the frame all bytes move together into a bank of four byte-wide receive registers. The same event raises a full flag and a level interrupt.

Software reads the registers through a small address/enable port. A read of register 0 both collects the data and acknowledges the frame. Reception stays disabled after reset until software issues one dummy read of register 0. The serial pins are brought into the system clock domain by synchronizers, so the system clock must run at least four times faster than the serial clock.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset `rxFull` and `rxIrq` are 0, all four receive registers read 0, and reception is disarmed.
- R2: Until the first read of register 0 (`rdEn`=1 with `rdAddr`=0), serial bits are ignored: a complete frame leaves `rxFull` at 0 and the registers unchanged.
- R3: A bit is taken on each synchronized rising edge of `sclkIn` while `selN` is low.
- R4: `lenSel` sets the frame length: 0 gives one byte, 1 gives two bytes, 2 or 3 gives four bytes. `rxFull` rises only once the whole frame has arrived, never after a single byte of a longer frame.
- R5: With `lsbFirst`=1 the first bit of each byte becomes bit 0. With `lsbFirst`=0 the first bit becomes bit 7.
- R6: Placement of bytes depends on bit order. MSB-first byte k of the frame (k=0 is the first byte received) lands in register k. LSB-first byte k lands in register N-1-k, where N is the frame length in bytes. Registers at or above N keep their value.
- R7: The receive registers change only at frame completion. All bytes of a frame appear in the same cycle, and a partly received frame is never visible.
- R8: A read of register 0 clears `rxFull` on the next cycle. Reads of registers 1 to 3 leave `rxFull` unchanged.
- R9: If `selN` rises before the frame is complete, the partial frame is discarded and `rxFull` and the registers are left as they were. The next frame starts again from its first bit.
- R10: A frame that completes while `rxFull` is 1 and register 0 is not being read in that cycle is dropped, and the previous register contents remain.
- R11: A frame that completes in the same cycle as a read of register 0 is accepted: the registers take the new data and `rxFull` stays 1.
- R12: `rxIrq` is a level signal equal to `rxFull` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclkIn | input | 1 | Serial clock, idles low, asynchronous to `clk` |
| selN | input | 1 | Active-low frame select |
| sdIn | input | 1 | Serial data input |
| lenSel | input | 2 | Frame length: 0 = 8, 1 = 16, 2/3 = 32 bits |
| lsbFirst | input | 1 | 1 = each byte arrives bit 0 first |
| rdEn | input | 1 | Register read strobe, one cycle per read |
| rdAddr | input | 2 | Receive register index for `rdData` and reads |
| rdData | output | 8 | Contents of the register selected by `rdAddr` |
| rxFull | output | 1 | Set when a frame has been accepted into the registers |
| rxIrq | output | 1 | Receive interrupt, level, follows `rxFull` |

## Verification
The completion of a frame and the acknowledging read of register 0 can occur in the same system clock cycle. This collision decides whether new data is accepted or dropped. The bench provokes it by timing a read strobe onto the third clock edge after the final serial clock rise, which is where the synchronizer latency places the frame end. It judges the result against a reference model that accepts the frame and keeps the flag set. The other side of the collision is also checked: a frame that ends while the flag is set and no read occurs must leave every register untouched.

// File: rtl/sfrx_pkg.sv
package sfrx_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 4;
  localparam int SLOT_W    = $clog2(MAX_BYTES);
  localparam int BIT_W     = $clog2(BYTE_W);

  typedef struct packed {
    logic                 shift;     // take one serial bit
    logic                 byteDone;  // this bit completes a byte
    logic [SLOT_W-1:0]    slot;      // register slot of the current byte
    logic                 load;      // commit staged frame to registers
    logic [MAX_BYTES-1:0] valid;     // slots that belong to the frame
  } rxStrobe_t;
endpackage

// File: rtl/sfrx_ctrl.sv
module sfrx_ctrl
  import sfrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       selN,
  input  logic       sdIn,
  input  logic [1:0] lenSel,
  input  logic       lsbFirst,
  input  logic       rd0,
  output rxStrobe_t  strb,
  output logic       sdBit,
  output logic       full,
  output logic       armed
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclkQ, selQ, sdQ;
  logic sclkPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ    <= '0;
      selQ     <= '1;
      sdQ      <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkQ    <= {sclkQ[TOP-1:0], sclkIn};
      selQ     <= {selQ[TOP-1:0], selN};
      sdQ      <= {sdQ[TOP-1:0], sdIn};
      sclkPrev <= sclkQ[TOP];
    end
  end

  logic rise, selAct;
  assign rise   = sclkQ[TOP] & ~sclkPrev;
  assign selAct = ~selQ[TOP];
  assign sdBit  = sdQ[TOP];

  logic [SLOT_W-1:0] lastIdx;
  logic [MAX_BYTES-1:0] validMask;
  always_comb begin
    case (lenSel)
      2'd0:    lastIdx = SLOT_W'(0);
      2'd1:    lastIdx = SLOT_W'(1);
      default: lastIdx = SLOT_W'(MAX_BYTES - 1);
    endcase
    for (int i = 0; i < MAX_BYTES; i++)
      validMask[i] = (i <= int'(lastIdx));
  end

  logic [BIT_W-1:0]  bitCnt;
  logic [SLOT_W-1:0] byteCnt;
  logic shiftEn, byteEnd, frameEnd;

  assign shiftEn  = rise & selAct & armed;
  assign byteEnd  = shiftEn && (bitCnt == BIT_W'(BYTE_W - 1));
  assign frameEnd = byteEnd && (byteCnt == lastIdx);

  always_comb begin
    strb.shift    = shiftEn;
    strb.byteDone = byteEnd;
    strb.slot     = lsbFirst ? (lastIdx - byteCnt) : byteCnt;
    strb.load     = frameEnd && (!full || rd0);
    strb.valid    = validMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      byteCnt <= '0;
      full    <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (!selAct) begin
        bitCnt  <= '0;
        byteCnt <= '0;
      end else if (shiftEn) begin
        bitCnt <= byteEnd ? '0 : bitCnt + 1'b1;
        if (frameEnd)     byteCnt <= '0;
        else if (byteEnd) byteCnt <= byteCnt + 1'b1;
      end
      if (strb.load) full <= 1'b1;
      else if (rd0)  full <= 1'b0;
      if (rd0) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/sfrx_dpath.sv
module sfrx_dpath
  import sfrx_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  rxStrobe_t                          strb,
  input  logic                               sdBit,
  input  logic                               lsbFirst,
  input  logic [SLOT_W-1:0]                  rdAddr,
  output logic [BYTE_W-1:0]                  rdData,
  output logic [MAX_BYTES-1:0][BYTE_W-1:0]   regFile
);
  logic [BYTE_W-1:0] curByte, nextByte;
  logic [MAX_BYTES-1:0][BYTE_W-1:0] stage;

  assign nextByte = lsbFirst ? {sdBit, curByte[BYTE_W-1:1]}
                             : {curByte[BYTE_W-2:0], sdBit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curByte <= '0;
      stage   <= '0;
    end else begin
      if (strb.shift)    curByte <= nextByte;
      if (strb.byteDone) stage[strb.slot] <= nextByte;
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)
        regFile[g] <= '0;
      else if (strb.load && strb.valid[g])
        regFile[g] <= (strb.slot == SLOT_W'(g)) ? nextByte : stage[g];
    end
  end

  assign rdData = regFile[rdAddr];
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import sfrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       selN,
  input  logic       sdIn,
  input  logic [1:0] lenSel,
  input  logic       lsbFirst,
  input  logic       rdEn,
  input  logic [1:0] rdAddr,
  output logic [7:0] rdData,
  output logic       rxFull,
  output logic       rxIrq
);
  rxStrobe_t strb;
  logic sdBit, armed, rd0;
  logic [MAX_BYTES-1:0][BYTE_W-1:0] regFile;

  assign rd0 = rdEn && (rdAddr == 2'd0);

  sfrx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .selN(selN), .sdIn(sdIn),
    .lenSel(lenSel), .lsbFirst(lsbFirst), .rd0(rd0),
    .strb(strb), .sdBit(sdBit), .full(rxFull), .armed(armed)
  );

  sfrx_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .sdBit(sdBit),
    .lsbFirst(lsbFirst), .rdAddr(rdAddr), .rdData(rdData),
    .regFile(regFile)
  );

  assign rxIrq = rxFull;
endmodule

// File: rtl/sfrx_checker.sv
module sfrx_checker
  import sfrx_pkg::*;
(
  input logic                             clk,
  input logic                             rstN,
  input logic                             rdEn,
  input logic [1:0]                       rdAddr,
  input logic                             rxFull,
  input logic                             rxIrq,
  input logic                             armed,
  input rxStrobe_t                        strb,
  input logic [MAX_BYTES-1:0][BYTE_W-1:0] regFile
);
  // R12
  irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq == rxFull);

  // R8
  ack_clears_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == 2'd0 && !strb.load) |=> !rxFull);

  // R7
  regs_hold_between_loads_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(regFile));

  // R10
  drop_while_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !(rdEn && rdAddr == 2'd0)) |=> (rxFull && $stable(regFile)));

  // R2
  idle_until_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !rxFull) |=> !rxFull);

  // R4
  flag_set_only_by_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxFull && !strb.load) |=> !rxFull);
endmodule

bind serial_frame_rx sfrx_checker u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr),
  .rxFull(rxFull), .rxIrq(rxIrq), .armed(armed), .strb(strb),
  .regFile(regFile)
);

// File: tb/serial_frame_rx_bench.sv
`timescale 1ns/1ps
module serial_frame_rx_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0, selN = 1'b1, sdIn = 1'b0;
  logic [1:0] lenSel = 2'd0, rdAddr = 2'd0;
  logic lsbFirst = 1'b0, rdEn = 1'b0;
  logic [7:0] rdData;
  logic rxFull, rxIrq;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  serial_frame_rx u_serial_frame_rx (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .selN(selN), .sdIn(sdIn),
    .lenSel(lenSel), .lsbFirst(lsbFirst), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .rxFull(rxFull), .rxIrq(rxIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic hS[3], hSel[3], hSd[3];
  logic [7:0] mReg[4];
  logic [7:0] mCur;
  logic [7:0] mBytes[$];
  int   mBit;
  bit   mFull, mArmed;

  initial begin
    for (int i = 0; i < 3; i++) begin hS[i] = 0; hSel[i] = 1; hSd[i] = 0; end
    for (int i = 0; i < 4; i++) mReg[i] = 0;
    mCur = 0; mBit = 0; mFull = 0; mArmed = 0;
  end

  always @(posedge clk) begin
    bit rise, act, d, rd0, done;
    int n;
    rise = hS[1] & ~hS[2];
    act  = !hSel[1];
    d    = hSd[1];
    if (!rstN) begin
      for (int i = 0; i < 4; i++) mReg[i] = 0;
      mBit = 0; mFull = 0; mArmed = 0; mBytes.delete();
    end else begin
      rd0  = rdEn && rdAddr == 2'd0;
      n    = (lenSel == 2'd0) ? 1 : (lenSel == 2'd1) ? 2 : 4;
      done = 0;
      if (!act) begin
        mBit = 0; mBytes.delete();
      end else if (rise && mArmed) begin
        if (lsbFirst) mCur[mBit] = d; else mCur[7 - mBit] = d;
        mBit++;
        if (mBit == 8) begin
          mBytes.push_back(mCur);
          mBit = 0;
          if (mBytes.size() == n) done = 1;
        end
      end
      if (done) begin
        if (!mFull || rd0) begin
          for (int k = 0; k < n; k++)
            mReg[lsbFirst ? n - 1 - k : k] = mBytes[k];
          mFull = 1;
        end
        mBytes.delete();
      end else if (rd0) begin
        mFull = 0;
      end
      if (rd0) mArmed = 1;
    end
    hS[2] = hS[1];     hS[1] = hS[0];     hS[0] = sclkIn;
    hSel[2] = hSel[1]; hSel[1] = hSel[0]; hSel[0] = selN;
    hSd[2] = hSd[1];   hSd[1] = hSd[0];   hSd[0] = sdIn;
  end

  always @(posedge clk) begin
    #2;
    if (rstN) begin
      check("R4 flag vs model", rxFull, mFull);
      check("R12 irq vs model", rxIrq, mFull);
      check("R6 rdData vs model", rdData, mReg[rdAddr]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readReg(input logic [1:0] a);
    @(negedge clk); rdEn = 1'b1; rdAddr = a;
    @(negedge clk); rdEn = 1'b0;
    #1;
  endtask

  task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); rdAddr = a;
    #1 check(tag, rdData, exp);
  endtask

  task automatic sendFrame(input logic [31:0] data, input int nBytes, input bit lsb,
                           input int abortAt, input bit readAtEnd);
    int total;
    total = nBytes * 8;
    @(negedge clk); selN = 1'b0;
    waitN(4);
    for (int i = 0; i < total; i++) begin
      logic [7:0] b;
      int j;
      if (abortAt > 0 && i == abortAt) break;
      b = data[8*(nBytes - 1 - i/8) +: 8];
      j = i % 8;
      sdIn = lsb ? b[j] : b[7 - j];
      sclkIn = 1'b0;
      waitN(4);
      sclkIn = 1'b1;
      if (readAtEnd && i == total - 1) begin
        waitN(2);
        rdEn = 1'b1; rdAddr = 2'd0;
        waitN(1);
        rdEn = 1'b0;
        waitN(1);
      end else begin
        waitN(4);
      end
    end
    sclkIn = 1'b0;
    waitN(4);
    selN = 1'b1;
    waitN(8);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  // ---------------- test sequence ----------------
  initial begin
    waitN(5);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 rxFull after reset", rxFull, 0);
    check("R1 rxIrq after reset", rxIrq, 0);
    for (int a = 0; a < 4; a++) peek(a[1:0], 8'h00, "R1 register after reset");

    // R2 frame ignored before arming
    lenSel = 2'd0; lsbFirst = 1'b0;
    sendFrame(32'hA5, 1, 0, 0, 0);
    check("R2 flag stays low unarmed", rxFull, 0);
    peek(2'd0, 8'h00, "R2 reg0 untouched unarmed");

    // arm with dummy read, then MSB-first byte
    readReg(2'd0);
    sendFrame(32'h3C, 1, 0, 0, 0);
    check("R3 flag after 8-bit frame", rxFull, 1);
    check("R12 irq with flag", rxIrq, 1);
    peek(2'd0, 8'h3C, "R5 MSB-first byte");

    // R8 reads of other registers keep flag, reg0 clears it
    readReg(2'd1);
    check("R8 reg1 read keeps flag", rxFull, 1);
    readReg(2'd3);
    check("R8 reg3 read keeps flag", rxFull, 1);
    readReg(2'd0);
    check("R8 reg0 read clears flag", rxFull, 0);
    check("R12 irq cleared", rxIrq, 0);

    // LSB-first byte
    lsbFirst = 1'b1;
    sendFrame(32'hC1, 1, 1, 0, 0);
    peek(2'd0, 8'hC1, "R5 LSB-first byte");
    readReg(2'd0);

    // R6 16-bit placement
    lenSel = 2'd1;
    sendFrame(32'h1234, 2, 1, 0, 0);
    peek(2'd1, 8'h12, "R6 16-bit LSB first byte to reg1");
    peek(2'd0, 8'h34, "R6 16-bit LSB second byte to reg0");
    readReg(2'd0);
    lsbFirst = 1'b0;
    sendFrame(32'h5678, 2, 0, 0, 0);
    peek(2'd0, 8'h56, "R6 16-bit MSB first byte to reg0");
    peek(2'd1, 8'h78, "R6 16-bit MSB second byte to reg1");
    readReg(2'd0);

    // R6 32-bit placement
    lenSel = 2'd2; lsbFirst = 1'b1;
    sendFrame(32'h11223344, 4, 1, 0, 0);
    peek(2'd3, 8'h11, "R6 32-bit LSB reg3");
    peek(2'd2, 8'h22, "R6 32-bit LSB reg2");
    peek(2'd1, 8'h33, "R6 32-bit LSB reg1");
    peek(2'd0, 8'h44, "R6 32-bit LSB reg0");
    readReg(2'd0);
    lenSel = 2'd3; lsbFirst = 1'b0;
    sendFrame(32'hAABBCCDD, 4, 0, 0, 0);
    peek(2'd0, 8'hAA, "R6 32-bit MSB reg0 (lenSel 3)");
    peek(2'd3, 8'hDD, "R6 32-bit MSB reg3 (lenSel 3)");
    readReg(2'd0);

    // R9 aborted frame discarded, then clean restart
    lenSel = 2'd1;
    sendFrame(32'h9999, 2, 0, 12, 0);
    check("R9 flag after abort", rxFull, 0);
    check("R4 no flag after partial frame", rxFull, 0);
    peek(2'd0, 8'hAA, "R9 reg0 kept after abort");
    peek(2'd1, 8'hBB, "R9 reg1 kept after abort");
    sendFrame(32'h0102, 2, 0, 0, 0);
    check("R9 restart frame accepted", rxFull, 1);
    peek(2'd0, 8'h01, "R9 restart reg0");
    peek(2'd1, 8'h02, "R9 restart reg1");

    // R10 frame dropped while full
    sendFrame(32'h7F80, 2, 0, 0, 0);
    check("R10 flag stays set", rxFull, 1);
    peek(2'd0, 8'h01, "R10 reg0 kept");
    peek(2'd1, 8'h02, "R10 reg1 kept");

    // R11 completion coincides with reg0 read
    sendFrame(32'h4455, 2, 0, 0, 1);
    check("R11 flag stays set on collision", rxFull, 1);
    peek(2'd0, 8'h44, "R11 reg0 new data");
    peek(2'd1, 8'h55, "R11 reg1 new data");

    // R7 three whole bytes received, frame aborted: nothing visible
    readReg(2'd0);
    lenSel = 2'd2;
    sendFrame(32'h01020304, 4, 0, 24, 0);
    check("R7 flag low after 3 of 4 bytes", rxFull, 0);
    peek(2'd0, 8'h44, "R7 reg0 unchanged");
    peek(2'd2, 8'hCC, "R7 reg2 unchanged");

    waitN(4);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule